// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide asynchronous parallel flash. It turns a single request into the bus traffic the flash needs. A request carries an operation code, a byte address and a data byte, and it is taken over a valid/ready handshake. The operations are a plain read, a byte program, and a sector, block or whole-chip erase. For each write-type operation the block emits the unlock write cycles and then the command write cycles. It shapes every write strobe from clock-count parameters, so the same logic fits any clock rate.

After the last command write, the block watches for the end of the internal operation by reading the target location repeatedly. While the flash is busy, bit 6 of the status byte alternates between reads; when it stops alternating, the operation has finished. A status read may land on the very cycle in which the flash finishes. To guard against that race, a matching pair of reads is only a candidate: two further reads must agree with it before the block reports completion. If the flash has not finished within a per-operation cycle budget, the block reports a timeout instead.

The result comes back as a single-cycle response pulse. The pulse carries a timeout flag and the last byte read. Plain reads are passed straight through as one bus read.

Top module: `flash_seq`

## Requirements
- R1: Operation code 1 (program) produces exactly four writes, in this order, as (address, data): (AAAh, AAh), (555h, 55h), (AAAh, A0h), then (request address, request data). Unlock addresses have all bits above bit 14 at zero.
- R2: Operation codes 2 (sector), 3 (block) and 4 (chip) produce exactly six writes, in this order: (AAAh, AAh), (555h, 55h), (AAAh, 80h), (AAAh, AAh), (555h, 55h), then a final write. The final write is (request address, 50h) for sector, (request address, 30h) for block, and (AAAh, 10h) for chip.
- R3: Every write strobe (fl_we_n low) lasts exactly WE_LO_CYC cycles. Consecutive strobes are separated by at least WE_HI_CYC high cycles. While the strobe is low, fl_oe_n is high, fl_dq_oe is 1, and the address and data stay constant.
- R4: fl_ce_n stays low without a break from the first write of a request until its response.
- R5: Completion is declared only after two successive status reads show equal bit 6 and two further reads agree with that value. The response then has rsp_timeout = 0 and arrives after the flash has stopped toggling.
- R6: If a matching pair of status reads is followed by a confirmation read that differs, the candidate is discarded and polling continues. A flash that repeats bit 6 once while still busy therefore does not end the operation.
- R7: If completion is not confirmed once TMO_PROG (program), TMO_ERASE (sector or block) or TMO_CHIP (chip) cycles have passed since polling began, the response carries rsp_timeout = 1.
- R8: No write strobe occurs within PWRUP_CYC cycles after reset is released. A write-type request accepted earlier than that is held until the interval has passed.
- R9: Operation code 0 (read) performs one bus read at the request address with no write. It returns the byte on rsp_data with rsp_timeout = 0, and it is not held by the power-up interval.
- R10: rsp_valid is high for exactly one cycle per request. req_ready is low from acceptance until after the response.
- R11: Operation codes 5, 6 and 7 cause no flash bus cycle and are answered with rsp_timeout = 1.
- R12: During reset, fl_ce_n, fl_oe_n and fl_we_n are high, fl_dq_oe and rsp_valid are 0, and req_ready is 1 once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle when valid is high |
| req_op | input | 3 | Operation code (0 read, 1 program, 2 sector, 3 block, 4 chip) |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_timeout | output | 1 | Operation not confirmed in budget, or bad operation code |
| rsp_data | output | 8 | Last byte read from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Data returned by the flash |

## Verification
The bench sweeps every write-type operation against a behavioural flash with short, medium and long busy periods. Against each run it compares the write trace and the strobe widths. The sharpest case is a flash that repeats bit 6 once while busy: a design without the confirmation reads would report completion early, with the flash still busy. Budget runs check that a timeout comes no sooner than the limit. A design with an off-by-one or wrong-limit counter would miss that window. A read issued straight after reset must return before the power-up interval, while the first write strobe must not come inside it. A sequencer that gated all requests would fail the first check, and one that ignored the interval would fail the second. Illegal operation codes must leave the bus untouched.

// File: rtl/flash_seq_pkg.sv
// Shared constants and state types for the flash sequencer.
package flash_seq_pkg;
    localparam logic [2:0] OP_READ = 3'd0;
    localparam logic [2:0] OP_PROG = 3'd1;
    localparam logic [2:0] OP_SECT = 3'd2;
    localparam logic [2:0] OP_BLK  = 3'd3;
    localparam logic [2:0] OP_CHIP = 3'd4;

    localparam logic [14:0] UNLK_A = 15'hAAA;
    localparam logic [14:0] UNLK_B = 15'h555;

    localparam logic [7:0] KEY1      = 8'hAA;
    localparam logic [7:0] KEY2      = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ERASE = 8'h80;
    localparam logic [7:0] CMD_SECT  = 8'h50;
    localparam logic [7:0] CMD_BLK   = 8'h30;
    localparam logic [7:0] CMD_CHIP  = 8'h10;

    typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_WRITE, ST_POLL, ST_READ, ST_RESP} seq_st_e;
    typedef enum logic [1:0] {PH_IDLE, PH_ACT, PH_REC} bus_ph_e;
    typedef enum logic [1:0] {PL_FIRST, PL_RUN, PL_CF1, PL_CF2} poll_ph_e;
endpackage

// File: rtl/flash_seq_cmd.sv
// Command table: gives the address and data of write number `step`
// for the latched operation. Purely combinational.
// Assumes op is one of the write-type codes; other codes fall to chip erase.
module flash_seq_cmd
    import flash_seq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic [2:0]    op,
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [7:0]    tgt_data,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [2:0]    last_step
);
    localparam logic [AW-1:0] ADR_A = AW'(UNLK_A);
    localparam logic [AW-1:0] ADR_B = AW'(UNLK_B);

    // Select the write for this step of the sequence.
    always_comb begin
        last_step = (op == OP_PROG) ? 3'd3 : 3'd5;
        wr_addr   = ADR_A;
        wr_data   = KEY1;
        if (op == OP_PROG) begin
            case (step)
                3'd1:    begin wr_addr = ADR_B;    wr_data = KEY2;     end
                3'd2:    begin wr_addr = ADR_A;    wr_data = CMD_PROG; end
                3'd3:    begin wr_addr = tgt_addr; wr_data = tgt_data; end
                default: begin wr_addr = ADR_A;    wr_data = KEY1;     end
            endcase
        end else begin
            case (step)
                3'd1: begin wr_addr = ADR_B; wr_data = KEY2;      end
                3'd2: begin wr_addr = ADR_A; wr_data = CMD_ERASE; end
                3'd3: begin wr_addr = ADR_A; wr_data = KEY1;      end
                3'd4: begin wr_addr = ADR_B; wr_data = KEY2;      end
                3'd5: begin
                    case (op)
                        OP_SECT: begin wr_addr = tgt_addr; wr_data = CMD_SECT; end
                        OP_BLK:  begin wr_addr = tgt_addr; wr_data = CMD_BLK;  end
                        default: begin wr_addr = ADR_A;    wr_data = CMD_CHIP; end
                    endcase
                end
                default: begin wr_addr = ADR_A; wr_data = KEY1; end
            endcase
        end
    end
endmodule

// File: rtl/flash_seq_bus.sv
// Bus cycle engine: runs one write or read cycle per start pulse.
// A cycle has an active phase (strobe low) and a recovery phase (strobe high),
// each a parameter number of clocks long. Read data is captured on the last
// active clock. Assumes start is only raised while idle is high.
module flash_seq_bus
    import flash_seq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int WE_LO_CYC = 4,
    parameter int WE_HI_CYC = 3,
    parameter int RD_LO_CYC = 8,
    parameter int RD_HI_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic [7:0]    dq_in,
    output logic          idle,
    output logic          done,
    output logic [7:0]    rdata,
    output logic          we_n,
    output logic          oe_n,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    dq_out,
    output logic          dq_oe
);
    localparam int MAX_A = (WE_LO_CYC > RD_LO_CYC) ? WE_LO_CYC : RD_LO_CYC;
    localparam int MAX_R = (WE_HI_CYC > RD_HI_CYC) ? WE_HI_CYC : RD_HI_CYC;
    localparam int MAX_C = (MAX_A > MAX_R) ? MAX_A : MAX_R;
    localparam int CW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    bus_ph_e       ph_q;
    logic [CW-1:0] cnt_q;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic [7:0]    rdata_q;
    logic [CW-1:0] act_last;
    logic [CW-1:0] rec_last;

    // Phase lengths for the current cycle type.
    always_comb begin
        act_last = wr_q ? CW'(WE_LO_CYC - 1) : CW'(RD_LO_CYC - 1);
        rec_last = wr_q ? CW'(WE_HI_CYC - 1) : CW'(RD_HI_CYC - 1);
    end

    // Phase sequencing, request latching and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q   <= PH_ACT;
                    cnt_q  <= '0;
                    wr_q   <= is_wr;
                    addr_q <= addr;
                    data_q <= wdata;
                end
                PH_ACT: if (cnt_q == act_last) begin
                    ph_q  <= PH_REC;
                    cnt_q <= '0;
                    if (!wr_q) rdata_q <= dq_in;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                PH_REC: if (cnt_q == rec_last) begin
                    ph_q  <= PH_IDLE;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Strobe and bus decode from the registered phase.
    always_comb begin
        idle   = (ph_q == PH_IDLE);
        done   = (ph_q == PH_REC) && (cnt_q == rec_last);
        we_n   = !((ph_q == PH_ACT) && wr_q);
        oe_n   = !((ph_q == PH_ACT) && !wr_q);
        dq_oe  = (ph_q == PH_ACT) && wr_q;
        dq_out = data_q;
        addr_o = addr_q;
        rdata  = rdata_q;
    end

    // Run length of the current low strobe, kept for checking only.
    logic [CW:0] lo_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_run_q <= '0;
        else if (!we_n) lo_run_q <= lo_run_q + 1'b1;
        else            lo_run_q <= '0;
    end

    // R3
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (lo_run_q == (CW+1)'(WE_LO_CYC)));
    // R3
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(dq_out) && $stable(addr_o) && dq_oe));
endmodule

// File: rtl/flash_seq_poll.sv
// Toggle-bit judge: fed bit 6 of each status read, it flags completion when
// two successive reads match and two further reads agree with them.
// Assumes clr and rd_ok are never high together.
module flash_seq_poll
    import flash_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rd_ok,
    input  logic bit6,
    output logic done_now
);
    poll_ph_e ph_q;
    logic     ref_q;

    // A confirmed match on the second extra read ends the poll.
    always_comb done_now = rd_ok && (ph_q == PL_CF2) && (bit6 == ref_q);

    // Track the last bit value and the confirmation progress.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ph_q  <= PL_FIRST;
            ref_q <= 1'b0;
        end else if (rd_ok) begin
            case (ph_q)
                PL_FIRST: begin ref_q <= bit6; ph_q <= PL_RUN; end
                PL_RUN:   if (bit6 == ref_q) ph_q <= PL_CF1;
                          else ref_q <= bit6;
                PL_CF1:   if (bit6 == ref_q) ph_q <= PL_CF2;
                          else begin ref_q <= bit6; ph_q <= PL_RUN; end
                PL_CF2:   if (bit6 != ref_q) begin ref_q <= bit6; ph_q <= PL_RUN; end
                default:  ph_q <= PL_FIRST;
            endcase
        end
    end

    // R6
    cand_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && !clr && (ph_q == PL_CF1) && (bit6 != ref_q)) |=> (ph_q == PL_RUN));
endmodule

// File: rtl/flash_seq.sv
// Flash program/erase sequencer top. Accepts one request at a time, issues
// the unlock and command writes, polls the toggling status bit with a
// two-read confirmation, and returns a one-cycle response.
// Assumes the flash reacts to OE falling edges for toggling and that all
// timing parameters are at least 1.
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int WE_LO_CYC = 4,
    parameter int WE_HI_CYC = 3,
    parameter int RD_LO_CYC = 8,
    parameter int RD_HI_CYC = 2,
    parameter int PWRUP_CYC = 10000,
    parameter int TMO_PROG  = 2000,
    parameter int TMO_ERASE = 2500000,
    parameter int TMO_CHIP  = 10000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          rsp_valid,
    output logic          rsp_timeout,
    output logic [7:0]    rsp_data,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in
);
    localparam int TMO_M1  = (TMO_PROG > TMO_ERASE) ? TMO_PROG : TMO_ERASE;
    localparam int TMO_MAX = (TMO_M1 > TMO_CHIP) ? TMO_M1 : TMO_CHIP;
    localparam int TW      = $clog2(TMO_MAX + 2);
    localparam int PW      = $clog2(PWRUP_CYC + 2);

    seq_st_e       st_q;
    logic [2:0]    op_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic [2:0]    step_q;
    logic [TW-1:0] tmo_q;
    logic [PW-1:0] pwr_q;
    logic          rtmo_q;
    logic [7:0]    rdat_q;

    logic          pwr_ok;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_data;
    logic [2:0]    last_step;
    logic          bus_idle, bus_done, cyc_start, cyc_wr;
    logic [AW-1:0] cyc_addr;
    logic [7:0]    bus_rdata;
    logic          poll_clr, poll_rd, poll_done;
    logic [TW-1:0] tmo_lim;

    flash_seq_cmd #(.AW(AW)) u_cmd (
        .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
        .wr_addr(cmd_addr), .wr_data(cmd_data), .last_step(last_step)
    );

    flash_seq_bus #(
        .AW(AW), .WE_LO_CYC(WE_LO_CYC), .WE_HI_CYC(WE_HI_CYC),
        .RD_LO_CYC(RD_LO_CYC), .RD_HI_CYC(RD_HI_CYC)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .start(cyc_start), .is_wr(cyc_wr),
        .addr(cyc_addr), .wdata(cmd_data), .dq_in(fl_dq_in),
        .idle(bus_idle), .done(bus_done), .rdata(bus_rdata),
        .we_n(fl_we_n), .oe_n(fl_oe_n), .addr_o(fl_addr),
        .dq_out(fl_dq_out), .dq_oe(fl_dq_oe)
    );

    flash_seq_poll u_poll (
        .clk(clk), .rst_n(rst_n), .clr(poll_clr), .rd_ok(poll_rd),
        .bit6(bus_rdata[6]), .done_now(poll_done)
    );

    // Power-up hold counter; saturates once the interval has passed.
    always_ff @(posedge clk) begin
        if (!rst_n)      pwr_q <= '0;
        else if (!pwr_ok) pwr_q <= pwr_q + 1'b1;
    end
    assign pwr_ok = (pwr_q >= PW'(PWRUP_CYC));

    // Bus cycle launch and per-operation budget selection.
    always_comb begin
        cyc_start = ((st_q == ST_WRITE) || (st_q == ST_POLL) || (st_q == ST_READ)) && bus_idle;
        cyc_wr    = (st_q == ST_WRITE);
        cyc_addr  = (st_q == ST_WRITE) ? cmd_addr : addr_q;
        poll_clr  = (st_q == ST_WRITE) && bus_done && (step_q == last_step);
        poll_rd   = (st_q == ST_POLL) && bus_done;
        case (op_q)
            OP_PROG:         tmo_lim = TW'(TMO_PROG);
            OP_SECT, OP_BLK: tmo_lim = TW'(TMO_ERASE);
            default:         tmo_lim = TW'(TMO_CHIP);
        endcase
    end

    // Request sequencing from acceptance to response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_READ;
            addr_q <= '0;
            data_q <= '0;
            step_q <= '0;
            tmo_q  <= '0;
            rtmo_q <= 1'b0;
            rdat_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    op_q   <= req_op;
                    addr_q <= req_addr;
                    data_q <= req_data;
                    step_q <= '0;
                    rtmo_q <= 1'b0;
                    if (req_op == OP_READ)      st_q <= ST_READ;
                    else if (req_op <= OP_CHIP) st_q <= ST_HOLD;
                    else begin
                        st_q   <= ST_RESP;
                        rtmo_q <= 1'b1;
                        rdat_q <= '0;
                    end
                end
                ST_HOLD: if (pwr_ok) st_q <= ST_WRITE;
                ST_WRITE: if (bus_done) begin
                    if (step_q == last_step) begin
                        st_q  <= ST_POLL;
                        tmo_q <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_POLL: begin
                    tmo_q <= tmo_q + 1'b1;
                    if (bus_done) begin
                        if (poll_done) begin
                            st_q   <= ST_RESP;
                            rtmo_q <= 1'b0;
                            rdat_q <= bus_rdata;
                        end else if (tmo_q >= tmo_lim) begin
                            st_q   <= ST_RESP;
                            rtmo_q <= 1'b1;
                            rdat_q <= bus_rdata;
                        end
                    end
                end
                ST_READ: if (bus_done) begin
                    st_q   <= ST_RESP;
                    rdat_q <= bus_rdata;
                end
                ST_RESP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Handshake, response and chip-enable decode.
    always_comb begin
        req_ready   = (st_q == ST_IDLE);
        rsp_valid   = (st_q == ST_RESP);
        rsp_timeout = rtmo_q;
        rsp_data    = rdat_q;
        fl_ce_n     = !((st_q == ST_WRITE) || (st_q == ST_POLL) || (st_q == ST_READ));
    end

    // R4
    we_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_ce_n);
    // R8
    pwrup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> pwr_ok);
    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9
    read_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READ) |-> fl_we_n);
endmodule

// File: tb/flash_seq_test.sv
// Bench with a behavioural flash: it toggles bit 6 on each OE falling edge
// while busy, can skip one toggle, and otherwise returns addr[7:0]^5Ah.
module flash_seq_test;
    import flash_seq_pkg::*;

    localparam int AW = 20, WE_LO = 3, WE_HI = 2, RD_LO = 2, RD_HI = 1;
    localparam int PWRUP = 60, T_PROG = 200, T_ERASE = 400, T_CHIP = 600;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic req_ready, rsp_valid, rsp_timeout, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
    logic [7:0] rsp_data, fl_dq_out, fl_dq_in;
    logic [AW-1:0] fl_addr;

    always #5 clk = ~clk;

    flash_seq #(.AW(AW), .WE_LO_CYC(WE_LO), .WE_HI_CYC(WE_HI), .RD_LO_CYC(RD_LO),
        .RD_HI_CYC(RD_HI), .PWRUP_CYC(PWRUP), .TMO_PROG(T_PROG),
        .TMO_ERASE(T_ERASE), .TMO_CHIP(T_CHIP)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_data(rsp_data),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in));

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int cyc = 0;

    // responder state
    int busy = 0, busy_len_cfg = 0, stut_cfg = 0, exp_nw = 99;
    int rw_n = 0, rd_idx = 0, busy_start_cyc = 0, busy_end_cyc = 0;
    logic tog = 1'b0, prev_oe = 1'b1, prev_we = 1'b1;

    assign fl_dq_in = (busy != 0) ? {1'b0, tog, 6'h15} : (fl_addr[7:0] ^ 8'h5A);

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
    end

    // behavioural flash
    always @(posedge clk) begin
        prev_oe <= fl_oe_n;
        prev_we <= fl_we_n;
        if (req_valid && req_ready) begin
            rw_n <= 0;
            rd_idx <= 0;
        end else begin
            if (!prev_we && fl_we_n) begin
                rw_n <= rw_n + 1;
                if (rw_n + 1 == exp_nw) begin
                    busy <= busy_len_cfg;
                    busy_start_cyc <= cyc;
                end
            end else if (busy != 0) begin
                busy <= busy - 1;
                if (busy == 1) busy_end_cyc <= cyc;
            end
            if (prev_oe && !fl_oe_n && busy != 0) begin
                rd_idx <= rd_idx + 1;
                if (rd_idx + 1 != stut_cfg) tog <= ~tog;
            end
        end
    end

    // bus monitor
    logic [AW-1:0] wa [0:7];
    logic [7:0] wd [0:7];
    int wn = 0, lo = 0, hi = 1000, width_err = 0, ctl_err = 0, stab_err = 0;
    int gap_err = 0, ce_err = 0, first_we_cyc = -1;
    bit seq_on = 0;
    logic [AW-1:0] cur_a;
    logic [7:0] cur_d;

    always @(negedge clk) begin
        if (req_valid && req_ready) begin
            wn = 0; hi = 1000; seq_on = 0;
        end
        if (rsp_valid) seq_on = 0;
        if (seq_on && fl_ce_n) ce_err++;
        if (rst_n && !fl_we_n) begin
            if (first_we_cyc < 0) first_we_cyc = cyc;
            if (lo == 0) begin
                cur_a = fl_addr; cur_d = fl_dq_out; seq_on = 1;
                if (hi < WE_HI) gap_err++;
            end else if (fl_addr != cur_a || fl_dq_out != cur_d) stab_err++;
            if (!fl_oe_n || fl_ce_n || !fl_dq_oe) ctl_err++;
            lo++;
        end else if (lo != 0) begin
            if (lo != WE_LO) width_err++;
            if (wn < 8) begin wa[wn] = cur_a; wd[wn] = cur_d; end
            wn++; lo = 0; hi = 1;
        end else if (hi < 1000) hi++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ea(input logic [2:0] op, input int i, input logic [AW-1:0] t);
        if (op == OP_PROG) return (i == 3) ? t : (i == 1) ? AW'(15'h555) : AW'(15'hAAA);
        if (i == 1 || i == 4) return AW'(15'h555);
        if (i == 5) return (op == OP_CHIP) ? AW'(15'hAAA) : t;
        return AW'(15'hAAA);
    endfunction

    function automatic logic [7:0] ed(input logic [2:0] op, input int i, input logic [7:0] d);
        if (op == OP_PROG) case (i) 0: return 8'hAA; 1: return 8'h55; 2: return 8'hA0; default: return d; endcase
        case (i)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2: return 8'h80;
            default: return (op == OP_SECT) ? 8'h50 : (op == OP_BLK) ? 8'h30 : 8'h10;
        endcase
    endfunction

    int r_cyc;
    logic r_tmo;
    logic [7:0] r_dat;

    task automatic run(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input int blen, input int stut);
        int w;
        busy_len_cfg = blen;
        stut_cfg = stut;
        exp_nw = (op == OP_PROG) ? 4 : (op >= OP_SECT && op <= OP_CHIP) ? 6 : 99;
        @(posedge clk); #1;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        while (!req_ready) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(!req_ready, "R10", "ready low after accept", req_ready, 0);
        w = 0;
        while (!rsp_valid && w < 20000) begin @(posedge clk); #1; w++; end
        check(w < 20000, "R10", "response arrives", w, 0);
        r_cyc = cyc; r_tmo = rsp_timeout; r_dat = rsp_data;
        @(posedge clk); #1;
        check(!rsp_valid, "R10", "rsp_valid single cycle", rsp_valid, 0);
        while (busy != 0) begin @(posedge clk); #1; end
    endtask

    task automatic do_write_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                               input int blen, input int stut, input bit exp_tmo);
        int e0, e1, e2, e3, e4, nwe, lim, bad;
        e0 = width_err; e1 = ctl_err; e2 = stab_err; e3 = gap_err; e4 = ce_err;
        run(op, a, d, blen, stut);
        nwe = (op == OP_PROG) ? 4 : 6;
        check(wn == nwe, (op == OP_PROG) ? "R1" : "R2", "write count", wn, nwe);
        bad = 0;
        for (int i = 0; i < nwe && i < 8; i++)
            if (wa[i] != ea(op, i, a) || wd[i] != ed(op, i, d)) bad++;
        check(bad == 0, (op == OP_PROG) ? "R1" : "R2", "write sequence", bad, 0);
        check(width_err == e0 && ctl_err == e1 && stab_err == e2 && gap_err == e3,
              "R3", "strobe shape", width_err - e0 + ctl_err - e1 + stab_err - e2 + gap_err - e3, 0);
        check(ce_err == e4, "R4", "chip enable held", ce_err - e4, 0);
        lim = (op == OP_PROG) ? T_PROG : (op == OP_CHIP) ? T_CHIP : T_ERASE;
        if (exp_tmo) begin
            check(r_tmo == 1'b1, "R7", "timeout flag", r_tmo, 1);
            check((r_cyc - busy_start_cyc) >= lim && (r_cyc - busy_start_cyc) <= lim + 16,
                  "R7", "timeout instant", r_cyc - busy_start_cyc, lim);
        end else begin
            check(r_tmo == 1'b0, stut != 0 ? "R6" : "R5", "completion flag", r_tmo, 0);
            check(r_cyc > busy_end_cyc && r_cyc <= busy_end_cyc + 40,
                  stut != 0 ? "R6" : "R5", "completion after busy end", r_cyc, busy_end_cyc);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe && !rsp_valid, "R12",
              "reset outputs", {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, rsp_valid}, 5'b11100);
        @(posedge clk); #1;
        rst_n = 1'b1;
        #1;
        check(req_ready == 1'b1, "R12", "ready after reset", req_ready, 1);

        // R9: read right after reset, not held by power-up
        run(OP_READ, 20'h1_2345, 8'h00, 0, 0);
        check(r_dat == (8'h45 ^ 8'h5A) && !r_tmo, "R9", "read data", r_dat, 8'h45 ^ 8'h5A);
        check(wn == 0, "R9", "read makes no write", wn, 0);
        check(r_cyc < PWRUP, "R9", "read not held by power-up", r_cyc, PWRUP);

        // R8: first program waits out power-up
        do_write_op(OP_PROG, 20'h0_0123, 8'h3C, 20, 0, 0);
        check(first_we_cyc >= PWRUP, "R8", "first strobe after power-up", first_we_cyc, PWRUP);

        // R1 R2 R5 sweep over operations and busy lengths
        for (int op = 1; op <= 4; op++)
            for (int k = 0; k < 3; k++)
                do_write_op(3'(op), AW'(20'h3_7000 + op * 4097 + k * 33), 8'(op * 37 + k),
                            (k == 0) ? 4 : (k == 1) ? 37 : 150, 0, 0);

        // R6: one skipped toggle while busy must not end the operation
        do_write_op(OP_SECT, 20'h5_4000, 8'h00, 200, 3, 0);
        do_write_op(OP_PROG, 20'h0_0F0F, 8'hA5, 150, 5, 0);

        // R7: budgets per operation kind
        do_write_op(OP_PROG, 20'h0_1111, 8'h11, 1000, 0, 1);
        do_write_op(OP_BLK, 20'h2_0000, 8'h00, 2000, 0, 1);
        do_write_op(OP_CHIP, 20'h0_0000, 8'h00, 3000, 0, 1);

        // R11: illegal codes
        for (int op = 5; op <= 7; op++) begin
            run(3'(op), 20'h0_0AAA, 8'hFF, 0, 0);
            check(r_tmo == 1'b1, "R11", "illegal op flagged", r_tmo, 1);
            check(wn == 0 && !seq_on, "R11", "illegal op no bus cycle", wn, 0);
        end

        // R9: read after writes
        run(OP_READ, 20'h0_00C3, 8'h00, 0, 0);
        check(r_dat == (8'hC3 ^ 8'h5A), "R9", "second read data", r_dat, 8'hC3 ^ 8'h5A);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule